// File: doc/BRIEF.md
# Opcode Fetch and Refresh Cycle Generator

This block produces the instruction-fetch bus cycle of an 8-bit processor core. Each cycle spans four processor states (T1 to T4). In the first two states the program counter sits on the address bus and memory is read under active-low M1, MREQ and RD strobes. The byte is captured on the edge that enters T3. In T3 and T4 the address bus carries a dynamic-memory refresh address, with the interrupt-vector byte high and the refresh counter low, while RFSH is low and MREQ pulses a second time.

The block runs from a clock at twice the processor state rate, so one `clk` period is one half of a T-state. Phase 0 is the high half of T1, phase 1 is its low half, and so on up to phase 7, the low half of T4. Every falling edge of the processor clock therefore lands on a `clk` edge. While `fetch_go_i` is high, fetches run back to back. A halt input turns a fetch into a bus-only cycle: the byte read is dropped, a NOP (0x00) is presented, and the program counter holds.

Top module: `fetch_refresh_gen`

## Requirements
- R1: After synchronous reset, all four strobes are high, the address equals the program-counter reset value, the opcode is 0x00, the valid pulse is low and the refresh counter holds its reset value.
- R2: In phase 0, the address is the program counter, M1 is low, and MREQ and RD are high. In phases 1 to 3, M1, MREQ and RD are all low and the address stays on the program counter. RD is never low while MREQ is high.
- R3: The data byte is captured on the edge that enters phase 4. From phase 4 on, M1, MREQ and RD are high and the opcode output holds the captured byte until the next capture.
- R4: In phases 4 to 7, RFSH is low and the address is {interrupt-vector byte, refresh counter}. MREQ is low only in phases 5 and 6.
- R5: At the end of each fetch, bits 6:0 of the refresh counter increment modulo 128 and bit 7 is unchanged.
- R6: The halt input is sampled on the edge that starts a fetch. A halted fetch still runs the full strobe sequence, outputs opcode 0x00 and leaves the program counter unchanged.
- R7: A fetch that is not halted advances the program counter by one at its end, wrapping modulo 2^16.
- R8: M1 and RFSH are never low at the same time.
- R9: The opcode-valid output is high for exactly one `clk` cycle, the one that follows phase 7 of a fetch.
- R10: If `fetch_go_i` is low at the end of phase 7 (or while idle), the block idles with all strobes high and the address on the program counter. A high `fetch_go_i` sampled on an edge starts phase 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst | input | 1 | Synchronous active-high reset |
| fetch_go_i | input | 1 | Start or continue fetching |
| halt_i | input | 1 | Halt state; sampled at fetch start |
| ivec_i | input | 8 | Interrupt-vector byte for the refresh address |
| data_i | input | 8 | Memory read data |
| addr_o | output | 16 | Address bus |
| m1_n_o | output | 1 | Opcode-fetch strobe, active low |
| mreq_n_o | output | 1 | Memory request, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| rfsh_n_o | output | 1 | Refresh strobe, active low |
| opcode_o | output | 8 | Captured opcode (0x00 when halted) |
| op_valid_o | output | 1 | One-cycle pulse after T4 |

## Verification
If `fetch_go_i` is sampled high on edge E0, phase k is visible after edge E0+k. The opcode changes after E0+4, and the valid pulse, the new program counter and the refresh count appear after E0+8. The bench drives inputs and samples outputs on falling edges only. It walks a reference phase counter edge by edge and compares every phase's strobes and address against that count. A combinational memory model in the bench supplies read data from the address, so the expected opcode is known at the phase-4 sample.

// File: rtl/frg_pkg.sv
package frg_pkg;
  localparam int NPH      = 8;               // half T-states per fetch
  localparam int PW       = $clog2(NPH);
  localparam int CAP_PH   = 4;               // first phase of refresh half

  typedef struct packed {
    logic m1_n;
    logic mreq_n;
    logic rd_n;
    logic rfsh_n;
    logic sel_rfsh;
  } strobe_t;

  localparam strobe_t STB_IDLE = '{m1_n: 1'b1, mreq_n: 1'b1, rd_n: 1'b1,
                                   rfsh_n: 1'b1, sel_rfsh: 1'b0};

  function automatic strobe_t phase_decode(input logic busy, input logic [PW-1:0] ph);
    strobe_t s;
    s = STB_IDLE;
    if (busy) begin
      case (ph)
        3'd0: s.m1_n = 1'b0;
        3'd1, 3'd2, 3'd3: begin
          s.m1_n = 1'b0; s.mreq_n = 1'b0; s.rd_n = 1'b0;
        end
        3'd4, 3'd7: begin
          s.rfsh_n = 1'b0; s.sel_rfsh = 1'b1;
        end
        default: begin
          s.rfsh_n = 1'b0; s.sel_rfsh = 1'b1; s.mreq_n = 1'b0;
        end
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/frg_seq.sv
module frg_seq
  import frg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  output logic          nxt_busy,
  output logic [PW-1:0] nxt_ph,
  output logic          start_ev,
  output logic          cap_ev,
  output logic          done_ev
);
  localparam logic [PW-1:0] LAST   = PW'(NPH - 1);
  localparam logic [PW-1:0] PRECAP = PW'(CAP_PH - 1);

  logic          busy_q;
  logic [PW-1:0] ph_q;

  always_comb begin
    if (!busy_q || ph_q == LAST) begin
      nxt_busy = go_i;
      nxt_ph   = '0;
    end else begin
      nxt_busy = 1'b1;
      nxt_ph   = ph_q + PW'(1);
    end
  end

  assign done_ev  = busy_q && (ph_q == LAST);
  assign cap_ev   = busy_q && (ph_q == PRECAP);
  assign start_ev = go_i && (!busy_q || ph_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      busy_q <= nxt_busy;
      ph_q   <= nxt_ph;
    end
  end

  // a fetch, once begun, runs all its phases
  assert_fetch_runs_out_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ph_q != LAST) |=> busy_q);
endmodule

// File: rtl/frg_strobe.sv
module frg_strobe
  import frg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          nxt_busy,
  input  logic [PW-1:0] nxt_ph,
  output strobe_t       stb_q
);
  always_ff @(posedge clk) begin
    if (rst) stb_q <= STB_IDLE;
    else     stb_q <= phase_decode(nxt_busy, nxt_ph);
  end

  assert_rd_within_mreq_R2: assert property (@(posedge clk) disable iff (rst)
    !stb_q.rd_n |-> !stb_q.mreq_n);
  assert_rfsh_uses_refresh_addr_R4: assert property (@(posedge clk) disable iff (rst)
    !stb_q.rfsh_n |-> stb_q.sel_rfsh);
endmodule

// File: rtl/frg_regs.sv
module frg_regs #(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter int          RW         = 8,
  parameter logic [15:0] PC_RESET   = 16'h0000,
  parameter logic [7:0]  REFR_RESET = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_ev,
  input  logic          cap_ev,
  input  logic          done_ev,
  input  logic          halt_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] pc_nxt,
  output logic [RW-1:0] refr_nxt,
  output logic [DW-1:0] opcode_q,
  output logic          valid_q
);
  localparam int CW = RW - 1;   // counting bits of the refresh register

  logic [AW-1:0] pc_q;
  logic [RW-1:0] refr_q;
  logic          halt_q;

  assign pc_nxt   = (done_ev && !halt_q) ? pc_q + AW'(1) : pc_q;
  assign refr_nxt = done_ev ? {refr_q[RW-1], refr_q[CW-1:0] + CW'(1)} : refr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= PC_RESET[AW-1:0];
      refr_q   <= REFR_RESET[RW-1:0];
      halt_q   <= 1'b0;
      opcode_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      refr_q  <= refr_nxt;
      valid_q <= done_ev;
      if (start_ev) halt_q <= halt_i;
      if (cap_ev)   opcode_q <= halt_q ? '0 : data_i;
    end
  end

  assert_halt_freezes_pc_R6: assert property (@(posedge clk) disable iff (rst)
    (done_ev && halt_q) |=> pc_q == $past(pc_q));
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  assert_opcode_held_R3: assert property (@(posedge clk) disable iff (rst)
    !cap_ev |=> $stable(opcode_q));
endmodule

// File: rtl/frg_addr.sv
module frg_addr #(
  parameter int AW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_rfsh,
  input  logic [AW-1:0] pc_nxt,
  input  logic [AW-RW-1:0] ivec_i,
  input  logic [RW-1:0] refr_nxt,
  input  logic [AW-1:0] pc_rst,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)           addr_q <= pc_rst;
    else if (sel_rfsh) addr_q <= {ivec_i, refr_nxt};
    else               addr_q <= pc_nxt;
  end
endmodule

// File: rtl/fetch_refresh_gen.sv
module fetch_refresh_gen
  import frg_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter logic [15:0] PC_RESET   = 16'h0000,
  parameter logic [7:0]  REFR_RESET = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_go_i,
  input  logic          halt_i,
  input  logic [7:0]    ivec_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic          m1_n_o,
  output logic          mreq_n_o,
  output logic          rd_n_o,
  output logic          rfsh_n_o,
  output logic [DW-1:0] opcode_o,
  output logic          op_valid_o
);
  localparam int RW = AW - 8;

  logic          nxt_busy;
  logic [PW-1:0] nxt_ph;
  logic          start_ev, cap_ev, done_ev;
  strobe_t       stb_q;
  strobe_t       stb_nxt;
  logic [AW-1:0] pc_nxt;
  logic [RW-1:0] refr_nxt;

  assign stb_nxt = phase_decode(nxt_busy, nxt_ph);

  frg_seq u_seq (
    .clk(clk), .rst(rst), .go_i(fetch_go_i),
    .nxt_busy(nxt_busy), .nxt_ph(nxt_ph),
    .start_ev(start_ev), .cap_ev(cap_ev), .done_ev(done_ev)
  );

  frg_strobe u_strobe (
    .clk(clk), .rst(rst), .nxt_busy(nxt_busy), .nxt_ph(nxt_ph), .stb_q(stb_q)
  );

  frg_regs #(.AW(AW), .DW(DW), .RW(RW), .PC_RESET(PC_RESET), .REFR_RESET(REFR_RESET)) u_regs (
    .clk(clk), .rst(rst), .start_ev(start_ev), .cap_ev(cap_ev), .done_ev(done_ev),
    .halt_i(halt_i), .data_i(data_i), .pc_nxt(pc_nxt), .refr_nxt(refr_nxt),
    .opcode_q(opcode_o), .valid_q(op_valid_o)
  );

  frg_addr #(.AW(AW), .RW(RW)) u_addr (
    .clk(clk), .rst(rst), .sel_rfsh(stb_nxt.sel_rfsh), .pc_nxt(pc_nxt),
    .ivec_i(ivec_i), .refr_nxt(refr_nxt), .pc_rst(PC_RESET[AW-1:0]), .addr_q(addr_o)
  );

  assign m1_n_o   = stb_q.m1_n;
  assign mreq_n_o = stb_q.mreq_n;
  assign rd_n_o   = stb_q.rd_n;
  assign rfsh_n_o = stb_q.rfsh_n;

  assert_m1_rfsh_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(!m1_n_o && !rfsh_n_o));
  assert_refresh_no_read_R4: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n_o |-> rd_n_o);
endmodule

// File: tb/fetch_refresh_gen_bench.sv
`timescale 1ns/1ps
module fetch_refresh_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        go, halt;
  logic [7:0]  ivec;
  logic [7:0]  data;
  logic [15:0] addr;
  logic        m1_n, mreq_n, rd_n, rfsh_n;
  logic [7:0]  opcode;
  logic        op_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] pc_e;
  logic [7:0]  rf_e;
  bit          exp_valid;

  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign data = memf(addr);

  fetch_refresh_gen #(.PC_RESET(16'hFFFE), .REFR_RESET(8'hFE)) u_fetch_refresh_gen (
    .clk(clk), .rst(rst), .fetch_go_i(go), .halt_i(halt), .ivec_i(ivec),
    .data_i(data), .addr_o(addr), .m1_n_o(m1_n), .mreq_n_o(mreq_n), .rd_n_o(rd_n),
    .rfsh_n_o(rfsh_n), .opcode_o(opcode), .op_valid_o(op_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // expected strobes packed as {m1,mreq,rd,rfsh}
  function automatic logic [3:0] exp_stb(input int k);
    case (k)
      0:       return 4'b0111;
      1, 2, 3: return 4'b0001;
      4, 7:    return 4'b1110;
      default: return 4'b1010;
    endcase
  endfunction

  task automatic fetch(input bit h);
    logic [15:0] a_e;
    go   = 1'b1;
    halt = h;
    ivec = 8'($urandom);
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 1) halt = ~h;   // later changes must not matter (R6)
      a_e = (k < 4) ? pc_e : {ivec, rf_e};
      chk({m1_n, mreq_n, rd_n, rfsh_n} == exp_stb(k),
          (k < 4) ? "R2 strobes" : "R4 strobes", {m1_n, mreq_n, rd_n, rfsh_n}, exp_stb(k));
      chk(addr == a_e, (k < 4) ? "R7 fetch address" : "R5 refresh address", addr, a_e);
      if (k == 0) chk(op_valid == exp_valid, "R9 valid pulse", op_valid, exp_valid);
      else        chk(op_valid == 1'b0, "R9 valid low mid-fetch", op_valid, 0);
      if (k == 4) begin
        chk(opcode == (h ? 8'h00 : memf(pc_e)), h ? "R6 halted NOP" : "R3 captured opcode",
            opcode, h ? 8'h00 : memf(pc_e));
        chk(!(m1_n == 1'b0 && rfsh_n == 1'b0), "R8 exclusive", {m1_n, rfsh_n}, 2'b10);
      end
    end
    if (!h) pc_e = pc_e + 16'd1;
    rf_e = {rf_e[7], rf_e[6:0] + 7'd1};
    exp_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    go = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk({m1_n, mreq_n, rd_n, rfsh_n} == 4'hF, "R10 idle strobes", {m1_n, mreq_n, rd_n, rfsh_n}, 4'hF);
      chk(addr == pc_e, "R10 idle address", addr, pc_e);
      chk(op_valid == (i == 0 ? exp_valid : 1'b0), "R9 valid on idle", op_valid, (i == 0) ? exp_valid : 1'b0);
    end
    exp_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; go = 1'b0; halt = 1'b0; ivec = 8'h00;
    pc_e = 16'hFFFE; rf_e = 8'hFE; exp_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk({m1_n, mreq_n, rd_n, rfsh_n} == 4'hF, "R1 reset strobes", {m1_n, mreq_n, rd_n, rfsh_n}, 4'hF);
    chk(addr == 16'hFFFE, "R1 reset address", addr, 16'hFFFE);
    chk(opcode == 8'h00 && op_valid == 1'b0, "R1 reset opcode/valid", {opcode, op_valid}, 0);
    idle(2);
    // directed: back-to-back with PC wrap, halted middle fetch, refresh bit 7 kept
    fetch(1'b0);
    fetch(1'b1);
    fetch(1'b0);
    fetch(1'b0);
    idle(1);
    fetch(1'b1);
    idle(3);
    // random mix, long enough to wrap the 7-bit refresh count
    for (int n = 0; n < 300; n++) begin
      fetch(($urandom % 4) == 0);
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end
    idle(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule